// File: doc/BRIEF.md
# Phase-Staggered Instruction Issue Sequencer

This block sequences the issue of wide instructions whose operations are sorted into ordered phases. Producers come before consumers: reader operations take no operands and go first, then compute, then calls, then pick and writer operations. Each instruction's issue is spread over three consecutive cycles. Its reader slots issue in the first cycle and its compute slots in the second. Its pick and writer slots issue together in the third. A new instruction enters every cycle. In steady state one cycle therefore issues the readers of instruction N, the compute slots of N-1 and the late (pick/writer) slots of N-2. Each of the three issue strobes carries the tag of its own instruction. The overlap does not drain at branches: the readers of later instructions issue in the same cycle as an earlier instruction's branch, before that branch has resolved.

Calls take no slot cycle of their own. When an instruction that carries calls moves from the compute stage into the late stage, every stage freezes. That instruction's calls then issue one per cycle, back to back. An external hold input (a callee running, or any other stall) freezes all three stages together. A mispredict input discards every younger instruction still in the stages. It then raises a one-cycle cancel for the reader results that issued speculatively, and restarts issue from the first phase of the corrected-path instruction. Late-stage writes and branches that have already issued are never revoked.

The controller has three named states. ST_RUN is the normal staggered issue. ST_CALL issues the calls of the late-stage instruction. ST_FLUSH is the single recovery cycle after a mispredict. The transitions are:
- ST_RUN to ST_CALL: the stages shift while the compute-stage instruction has a nonzero call count.
- ST_RUN to ST_FLUSH: mispredict is asserted.
- ST_CALL to ST_RUN: the last call issues.
- ST_FLUSH to ST_RUN: always, after one cycle.

Top module: `phase_issue_seq`

## Requirements
- R1: After reset no issue strobe, call strobe or cancel is active, and in_ready is high.
- R2: An instruction accepted at a clock edge (in_valid and in_ready high), with no stall, issues its reader slots in the next cycle. It issues its compute slots one cycle after that and its late slots one cycle after that. Each issue output carries the instruction's own tag and the matching slot mask (rd_ops from in_rd_ops, cp_ops from in_cp_ops, wr_ops from in_wr_ops).
- R3: With back-to-back input, one cycle issues readers for tag N, compute for tag N-1 and late slots for tag N-2 together.
- R4: A cycle with in_valid low leaves a hole that travels through the three stages without stalling the instructions around it.
- R5: While hold is high in ST_RUN, no issue strobe fires, in_ready is low and no stage advances. Issue resumes without loss or repetition when hold falls.
- R6: When an instruction with a call count k > 0 (in_calls) has issued its compute slots, all stages freeze. Its k calls then issue one per non-held cycle with call_idx 0 to k-1 and call_tag equal to its tag, and no phase strobe fires meanwhile. Its late slots then issue together with the next two instructions' compute and reader slots.
- R7: Hold pauses the call sequence. After the last call, hold in ST_RUN keeps all stages frozen.
- R8: In a ST_RUN cycle with mispredict high, no strobe fires and in_ready is low. Every instruction in the stages is discarded and never issues a further phase. In the following cycle cancel is high for exactly one cycle. Late slots that issued before the mispredict cycle stay issued.
- R9: In the cancel cycle in_ready is high (unless hold is high). The instruction accepted there issues its reader slots in the next cycle.
- R10: Mispredict takes priority over hold in ST_RUN.
- R11: Mispredict is ignored in ST_CALL: no cancel follows and the call sequence continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction accepted this cycle |
| in_tag | input | TAG_W | Instruction tag |
| in_rd_ops | input | SLOTS | Reader-phase slot mask |
| in_cp_ops | input | SLOTS | Compute-phase slot mask |
| in_calls | input | CALL_W | Number of calls in the instruction |
| in_wr_ops | input | SLOTS | Pick/writer-phase slot mask |
| hold | input | 1 | Call-active or stall: freeze all stages |
| mispredict | input | 1 | Last issued branch was mispredicted |
| rd_fire | output | 1 | Reader phase issues |
| rd_ops | output | SLOTS | Reader slot mask |
| rd_tag | output | TAG_W | Tag of reader-phase instruction |
| cp_fire | output | 1 | Compute phase issues |
| cp_ops | output | SLOTS | Compute slot mask |
| cp_tag | output | TAG_W | Tag of compute-phase instruction |
| call_fire | output | 1 | One call issues |
| call_idx | output | CALL_W | Index of the call within its instruction |
| call_tag | output | TAG_W | Tag of the calling instruction |
| wr_fire | output | 1 | Pick/writer phase issues |
| wr_ops | output | SLOTS | Pick/writer slot mask |
| wr_tag | output | TAG_W | Tag of late-phase instruction |
| cancel | output | 1 | Cancel retires of speculatively issued readers |

## Verification
The hardest states to reach are the overlaps of the control paths. One is a mispredict that arrives while hold is also high. Another is a mispredict raised during the call sequence, where it must be ignored. A third is a callee hold that lands between two back-to-back calls and again after the last one. The directed call scenario fills all three stages behind an instruction carrying two calls. It then raises mispredict in the same cycle as the first call and raises hold between the calls and after them, checking every cycle. The mispredict scenario fills the stages, raises hold and mispredict together right after the branch's late slots issue, and then follows the corrected-path instruction through all three phases.

// File: rtl/phase_issue_pkg.sv
package phase_issue_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_CALL  = 2'd1,
        ST_FLUSH = 2'd2
    } seq_state_e;
endpackage

// File: rtl/issue_stage_reg.sv
module issue_stage_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic         clear,
    input  logic         d_valid,
    input  logic [W-1:0] d_data,
    output logic         q_valid,
    output logic [W-1:0] q_data
);
    // One phase stage: holds an instruction until the sequencer shifts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_data  <= '0;
        end else if (clear) begin
            q_valid <= 1'b0;
        end else if (shift) begin
            q_valid <= d_valid;
            q_data  <= d_data;
        end
    end
endmodule

// File: rtl/issue_fsm.sv
module issue_fsm
    import phase_issue_pkg::*;
#(
    parameter int CALL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              mispredict,
    input  logic              mid_valid,
    input  logic [CALL_W-1:0] mid_calls,
    output seq_state_e        state,
    output logic              issue_en,
    output logic              shift,
    output logic              clear,
    output logic              cancel,
    output logic              call_fire,
    output logic [CALL_W-1:0] call_idx
);
    seq_state_e        nxt;
    logic [CALL_W-1:0] remain;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (mispredict)
                    nxt = ST_FLUSH;
                else if (!hold && mid_valid && (mid_calls != '0))
                    nxt = ST_CALL;
            end
            ST_CALL: begin
                if (call_fire && (remain == CALL_W'(1)))
                    nxt = ST_RUN;
            end
            ST_FLUSH: nxt = ST_RUN;
            default:  nxt = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        issue_en  = 1'b0;
        shift     = 1'b0;
        clear     = 1'b0;
        cancel    = 1'b0;
        call_fire = 1'b0;
        unique case (state)
            ST_RUN: begin
                issue_en = !hold && !mispredict;
                shift    = !hold && !mispredict;
                clear    = mispredict;
            end
            ST_CALL: begin
                call_fire = !hold && (remain != '0);
            end
            ST_FLUSH: begin
                cancel = 1'b1;
                shift  = !hold;
            end
            default: ;
        endcase
    end

    // Call counter: loaded as a calling instruction enters the late stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain   <= '0;
            call_idx <= '0;
        end else if (state == ST_RUN && nxt == ST_CALL) begin
            remain   <= mid_calls;
            call_idx <= '0;
        end else if (call_fire) begin
            remain   <= remain - CALL_W'(1);
            call_idx <= call_idx + CALL_W'(1);
        end
    end

    // R11: a mispredict seen during the call sequence never produces a cancel
    p_call_no_cancel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CALL) |=> !cancel);

    // R8: cancel lasts a single cycle
    p_cancel_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> !cancel);
endmodule

// File: rtl/phase_issue_seq.sv
module phase_issue_seq
    import phase_issue_pkg::*;
#(
    parameter int TAG_W  = 5,
    parameter int SLOTS  = 4,
    parameter int CALL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [SLOTS-1:0]  in_rd_ops,
    input  logic [SLOTS-1:0]  in_cp_ops,
    input  logic [CALL_W-1:0] in_calls,
    input  logic [SLOTS-1:0]  in_wr_ops,
    input  logic              hold,
    input  logic              mispredict,
    output logic              rd_fire,
    output logic [SLOTS-1:0]  rd_ops,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              cp_fire,
    output logic [SLOTS-1:0]  cp_ops,
    output logic [TAG_W-1:0]  cp_tag,
    output logic              call_fire,
    output logic [CALL_W-1:0] call_idx,
    output logic [TAG_W-1:0]  call_tag,
    output logic              wr_fire,
    output logic [SLOTS-1:0]  wr_ops,
    output logic [TAG_W-1:0]  wr_tag,
    output logic              cancel
);
    localparam int NSTG     = 3;
    localparam int WR_LSB   = 0;
    localparam int CALL_LSB = WR_LSB + SLOTS;
    localparam int CP_LSB   = CALL_LSB + CALL_W;
    localparam int RD_LSB   = CP_LSB + SLOTS;
    localparam int TAG_LSB  = RD_LSB + SLOTS;
    localparam int PW       = TAG_LSB + TAG_W;
    localparam int S_RD     = 0;
    localparam int S_CP     = 1;
    localparam int S_WR     = 2;

    seq_state_e      seq_state;
    logic            issue_en, seq_shift, seq_clear;
    logic [NSTG-1:0] st_v;
    logic [PW-1:0]   st_q [NSTG];
    logic [PW-1:0]   in_word;

    assign in_word  = {in_tag, in_rd_ops, in_cp_ops, in_calls, in_wr_ops};
    assign in_ready = seq_shift;

    issue_fsm #(.CALL_W(CALL_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (hold),
        .mispredict (mispredict),
        .mid_valid  (st_v[S_CP]),
        .mid_calls  (st_q[S_CP][CALL_LSB +: CALL_W]),
        .state      (seq_state),
        .issue_en   (issue_en),
        .shift      (seq_shift),
        .clear      (seq_clear),
        .cancel     (cancel),
        .call_fire  (call_fire),
        .call_idx   (call_idx)
    );

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        logic          d_v;
        logic [PW-1:0] d_w;
        if (g == 0) begin : g_head
            assign d_v = in_valid & in_ready;
            assign d_w = in_word;
        end else begin : g_body
            assign d_v = st_v[g-1];
            assign d_w = st_q[g-1];
        end
        issue_stage_reg #(.W(PW)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .shift   (seq_shift),
            .clear   (seq_clear),
            .d_valid (d_v),
            .d_data  (d_w),
            .q_valid (st_v[g]),
            .q_data  (st_q[g])
        );
    end

    assign rd_fire  = issue_en & st_v[S_RD];
    assign rd_ops   = st_q[S_RD][RD_LSB +: SLOTS];
    assign rd_tag   = st_q[S_RD][TAG_LSB +: TAG_W];
    assign cp_fire  = issue_en & st_v[S_CP];
    assign cp_ops   = st_q[S_CP][CP_LSB +: SLOTS];
    assign cp_tag   = st_q[S_CP][TAG_LSB +: TAG_W];
    assign wr_fire  = issue_en & st_v[S_WR];
    assign wr_ops   = st_q[S_WR][WR_LSB +: SLOTS];
    assign wr_tag   = st_q[S_WR][TAG_LSB +: TAG_W];
    assign call_tag = st_q[S_WR][TAG_LSB +: TAG_W];

    // R3: a shifting stage hands its instruction to the next phase unchanged
    p_stage_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_shift && st_v[S_RD]) |=> (st_v[S_CP] && st_q[S_CP] == $past(st_q[S_RD])));

    // R5: hold in ST_RUN freezes every stage
    p_hold_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_RUN && hold && !mispredict) |=>
        ($stable(st_v) && $stable(st_q[S_RD]) && $stable(st_q[S_CP]) && $stable(st_q[S_WR])));

    // R6: a call always belongs to an instruction held in the late stage
    p_call_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        call_fire |-> (st_v[S_WR] && !rd_fire && !cp_fire && !wr_fire));

    // R8: after a mispredict, cancel is raised and all stages are empty
    p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_RUN && mispredict) |=> (cancel && st_v == '0));
endmodule

// File: tb/phase_issue_seq_test.sv
module phase_issue_seq_test;
    localparam int TAG_W  = 5;
    localparam int SLOTS  = 4;
    localparam int CALL_W = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n, in_valid, in_ready, hold, mispredict;
    logic [TAG_W-1:0]  in_tag;
    logic [SLOTS-1:0]  in_rd_ops, in_cp_ops, in_wr_ops;
    logic [CALL_W-1:0] in_calls;
    logic              rd_fire, cp_fire, wr_fire, call_fire, cancel;
    logic [SLOTS-1:0]  rd_ops, cp_ops, wr_ops;
    logic [TAG_W-1:0]  rd_tag, cp_tag, wr_tag, call_tag;
    logic [CALL_W-1:0] call_idx;

    phase_issue_seq #(.TAG_W(TAG_W), .SLOTS(SLOTS), .CALL_W(CALL_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_tag(in_tag), .in_rd_ops(in_rd_ops), .in_cp_ops(in_cp_ops),
        .in_calls(in_calls), .in_wr_ops(in_wr_ops), .hold(hold),
        .mispredict(mispredict), .rd_fire(rd_fire), .rd_ops(rd_ops),
        .rd_tag(rd_tag), .cp_fire(cp_fire), .cp_ops(cp_ops), .cp_tag(cp_tag),
        .call_fire(call_fire), .call_idx(call_idx), .call_tag(call_tag),
        .wr_fire(wr_fire), .wr_ops(wr_ops), .wr_tag(wr_tag), .cancel(cancel)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    always @(posedge clk) cycles++;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        wait (cycles > 20000);
        fails++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        summary();
    end

    // Slot masks are derived from the tag so every check can predict them.
    task automatic drive(input logic v, input logic [TAG_W-1:0] t,
                         input logic [CALL_W-1:0] nc, input logic h, input logic mp);
        @(negedge clk);
        in_valid   = v;
        in_tag     = t;
        in_rd_ops  = t[3:0];
        in_cp_ops  = ~t[3:0];
        in_wr_ops  = t[3:0] ^ 4'hA;
        in_calls   = nc;
        hold       = h;
        mispredict = mp;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, '0, '0, 1'b0, 1'b0);
    endtask

    // Tag 0 means "this strobe must stay low".
    task automatic expect_cycle(input string req, input int erd, input int ecp,
                                input int ewr, input int ecall, input int eidx,
                                input logic ecancel, input logic eready);
        bit bad;
        bad = 0;
        checks++;
        if (erd == 0) bad |= rd_fire;
        else bad |= !rd_fire || (rd_tag != TAG_W'(erd)) || (rd_ops != erd[3:0]);
        if (ecp == 0) bad |= cp_fire;
        else bad |= !cp_fire || (cp_tag != TAG_W'(ecp)) || (cp_ops != 4'(~ecp[3:0]));
        if (ewr == 0) bad |= wr_fire;
        else bad |= !wr_fire || (wr_tag != TAG_W'(ewr)) || (wr_ops != (ewr[3:0] ^ 4'hA));
        if (ecall == 0) bad |= call_fire;
        else bad |= !call_fire || (call_tag != TAG_W'(ecall)) || (call_idx != CALL_W'(eidx));
        bad |= (cancel != ecancel) || (in_ready != eready);
        if (bad) begin
            fails++;
            $display("FAIL %s: actual rd=%0b/%0d cp=%0b/%0d wr=%0b/%0d call=%0b/%0d/%0d cancel=%0b ready=%0b expected rd=%0d cp=%0d wr=%0d call=%0d/%0d cancel=%0b ready=%0b",
                     req, rd_fire, rd_tag, cp_fire, cp_tag, wr_fire, wr_tag,
                     call_fire, call_tag, call_idx, cancel, in_ready,
                     erd, ecp, ewr, ecall, eidx, ecancel, eready);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        in_valid = 0; in_tag = '0; in_rd_ops = '0; in_cp_ops = '0;
        in_wr_ops = '0; in_calls = '0; hold = 0; mispredict = 0;
        repeat (3) @(negedge clk);
        #1;
        expect_cycle("R1 reset", 0, 0, 0, 0, 0, 1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_steady();
        drive(1, 1, 0, 0, 0); expect_cycle("R2 empty", 0, 0, 0, 0, 0, 0, 1);
        drive(1, 2, 0, 0, 0); expect_cycle("R2 readers", 1, 0, 0, 0, 0, 0, 1);
        drive(1, 3, 0, 0, 0); expect_cycle("R2 compute", 2, 1, 0, 0, 0, 0, 1);
        drive(1, 4, 0, 0, 0); expect_cycle("R3 diagonal", 3, 2, 1, 0, 0, 0, 1);
        idle();               expect_cycle("R3 diagonal", 4, 3, 2, 0, 0, 0, 1);
        idle();               expect_cycle("R2 drain", 0, 4, 3, 0, 0, 0, 1);
        idle();               expect_cycle("R2 drain", 0, 0, 4, 0, 0, 0, 1);
        idle();               expect_cycle("R2 empty", 0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic t_hold();
        drive(1, 5, 0, 0, 0); expect_cycle("R5 fill", 0, 0, 0, 0, 0, 0, 1);
        drive(1, 6, 0, 0, 0); expect_cycle("R5 fill", 5, 0, 0, 0, 0, 0, 1);
        drive(1, 7, 0, 1, 0); expect_cycle("R5 held", 0, 0, 0, 0, 0, 0, 0);
        drive(1, 7, 0, 1, 0); expect_cycle("R5 held", 0, 0, 0, 0, 0, 0, 0);
        drive(1, 7, 0, 0, 0); expect_cycle("R5 resume", 6, 5, 0, 0, 0, 0, 1);
        idle();               expect_cycle("R5 resume", 7, 6, 5, 0, 0, 0, 1);
        idle();               expect_cycle("R5 drain", 0, 7, 6, 0, 0, 0, 1);
        idle();               expect_cycle("R5 drain", 0, 0, 7, 0, 0, 0, 1);
        idle();               expect_cycle("R5 empty", 0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic t_call();
        drive(1, 8, 2, 0, 0);  expect_cycle("R6 fill", 0, 0, 0, 0, 0, 0, 1);
        drive(1, 9, 0, 0, 0);  expect_cycle("R6 fill", 8, 0, 0, 0, 0, 0, 1);
        drive(1, 10, 0, 0, 0); expect_cycle("R6 compute", 9, 8, 0, 0, 0, 0, 1);
        drive(0, 0, 0, 0, 1);  expect_cycle("R6 first call", 0, 0, 0, 8, 0, 0, 0);
        drive(0, 0, 0, 1, 0);  expect_cycle("R11 no cancel, R7 callee hold", 0, 0, 0, 0, 0, 0, 0);
        idle();                expect_cycle("R6 second call", 0, 0, 0, 8, 1, 0, 0);
        drive(0, 0, 0, 1, 0);  expect_cycle("R7 hold after calls", 0, 0, 0, 0, 0, 0, 0);
        idle();                expect_cycle("R6 late after calls", 10, 9, 8, 0, 0, 0, 1);
        idle();                expect_cycle("R6 drain", 0, 10, 9, 0, 0, 0, 1);
        idle();                expect_cycle("R6 drain", 0, 0, 10, 0, 0, 0, 1);
        idle();                expect_cycle("R6 empty", 0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic t_mispredict();
        drive(1, 11, 0, 0, 0); expect_cycle("R8 fill", 0, 0, 0, 0, 0, 0, 1);
        drive(1, 12, 0, 0, 0); expect_cycle("R8 fill", 11, 0, 0, 0, 0, 0, 1);
        drive(1, 13, 0, 0, 0); expect_cycle("R8 fill", 12, 11, 0, 0, 0, 0, 1);
        drive(1, 14, 0, 0, 0); expect_cycle("R8 branch issues", 13, 12, 11, 0, 0, 0, 1);
        drive(1, 15, 0, 1, 1); expect_cycle("R8 R10 mispredict over hold", 0, 0, 0, 0, 0, 0, 0);
        drive(1, 20, 0, 0, 0); expect_cycle("R8 R9 cancel", 0, 0, 0, 0, 0, 1, 1);
        idle();                expect_cycle("R9 restart readers", 20, 0, 0, 0, 0, 0, 1);
        idle();                expect_cycle("R8 no wrong path", 0, 20, 0, 0, 0, 0, 1);
        idle();                expect_cycle("R8 no wrong path", 0, 0, 20, 0, 0, 0, 1);
        idle();                expect_cycle("R8 empty", 0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic t_bubble();
        drive(1, 21, 0, 0, 0); expect_cycle("R4 fill", 0, 0, 0, 0, 0, 0, 1);
        idle();                expect_cycle("R4 readers", 21, 0, 0, 0, 0, 0, 1);
        drive(1, 22, 0, 0, 0); expect_cycle("R4 hole", 0, 21, 0, 0, 0, 0, 1);
        idle();                expect_cycle("R4 hole", 22, 0, 21, 0, 0, 0, 1);
        idle();                expect_cycle("R4 hole", 0, 22, 0, 0, 0, 0, 1);
        idle();                expect_cycle("R4 drain", 0, 0, 22, 0, 0, 0, 1);
        idle();                expect_cycle("R4 empty", 0, 0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        t_reset();
        t_steady();
        t_hold();
        t_call();
        t_mispredict();
        t_bubble();
        summary();
    end
endmodule